// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer Bank

This block holds a small set of independent down-counters behind a word-addressed register port. Each channel has a reload register and a control word. The control word carries an enable bit and a two-bit run-mode field. Software can read the live count and a pending flag. A dedicated acknowledge location clears the pending flag as a side effect of being read. Each channel also drives its own interrupt line.

A channel in one-shot mode counts down once from its reload value, flags expiry and rests at zero. A channel in repeating mode reloads itself each time it expires, so it flags an event once per period. Software normally writes the reload value while the channel is stopped and then sets the enable bit. It services an interrupt by reading the acknowledge location. Clearing the enable bit pauses the counter, and the paused value stays readable.

Top module: `dcnt_timer_bank`

## Requirements
- R1: After reset every reload value, control word, count and pending flag is zero, all interrupt lines are low and the read data bus is zero.
- R2: The word address is channel*8 + index. Index 0 is reload (read/write), 1 is control (read/write), 2 is count (read-only), 3 is status (read-only) and 4 is acknowledge. A read returns its data on the cycle after the read strobe. Writes to indices 2 to 7, and any access to a channel number at or above the channel count, change nothing, and such reads return zero apart from the mapped read-only registers.
- R3: Control bit 0 is the enable and bits [2:1] are the run mode: 0 means one-shot, 1 means repeating, and the values 2 and 3 act as one-shot. Control reads return only these three bits, with all other bits zero.
- R4: A control write that takes the enable from 0 to 1 copies the reload value into the counter on the following clock. From the clock after that, the counter drops by one per clock.
- R5: In one-shot mode the clock that brings the counter from 1 to 0 sets pending, and the counter then stays at 0.
- R6: In repeating mode with reload N, the counter runs N down to 1 and then reloads instead of reaching 0. Pending is set on every reload, once every N clocks.
- R7: A reload value of 0 behaves as 1, so the channel expires one clock after the load.
- R8: Clearing the enable freezes the counter, and its frozen value is readable. A later 0-to-1 enable restarts the count from the reload value.
- R9: Status bit 0 shows the channel's pending flag whether or not the channel is enabled. The channel's interrupt line equals that flag and stays high until the flag is acknowledged.
- R10: Reading a channel's acknowledge location clears its pending flag on that clock and returns zero data.
- R11: If an expiry and an acknowledge read of the same channel fall on the same clock, pending stays set.
- R12: Channels count, expire and acknowledge independently of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; every counter advances on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address: channel in the upper bits, register index in the lower three |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe; an acknowledge read clears pending |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read strobe |
| irq | output | NUM_CH | One interrupt line per channel, high while that channel is pending |

## Verification
The bench measures the exact clock on which an interrupt first rises after enable. A design that loaded late, or counted one tick too many, would raise the line a cycle away from the expected point. It times the gap between repeat expiries to catch a period of N+1 caused by passing through zero. It also places an acknowledge read on the very clock of a repeat expiry, where a design that let the clear win would drop an event. Further checks catch a zero reload that never fires, a paused counter that keeps drifting or misses its reload on restart, a write to a read-only or unmapped address that leaks into state, and one channel's acknowledge that disturbs another channel.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

   // register index inside one channel's window (low address bits)
   localparam int REG_IDX_W = 3;

   typedef enum logic [REG_IDX_W-1:0] {
      RI_LOAD   = 3'd0,
      RI_CTRL   = 3'd1,
      RI_COUNT  = 3'd2,
      RI_STATUS = 3'd3,
      RI_ACK    = 3'd4
   } reg_idx_e;

   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MD_ONCE   = 2'd0,
      MD_REPEAT = 2'd1
   } run_mode_e;

   // control word layout, decoded by the channel and the read mux alike
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_MODE_LSB = 1;

endpackage

// File: rtl/dcnt_channel.sv
module dcnt_channel
   import dcnt_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_we,
   input  logic              ctrl_we,
   input  logic              ack_re,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  load_val,
   output logic              en,
   output logic [MODE_W-1:0] mode,
   output logic [CNT_W-1:0]  count,
   output logic              pending
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0]  load_r;
   logic [CNT_W-1:0]  cnt_r;
   logic [MODE_W-1:0] mode_r;
   logic              en_r;
   logic              arm_r;
   logic              pend_r;

   logic              start;
   logic              running;
   logic              expire;
   logic              repeat_md;
   logic [CNT_W-1:0]  eff_load;

   assign start     = ctrl_we & wdata[CTRL_EN_BIT] & ~en_r;
   assign eff_load  = (load_r == '0) ? ONE : load_r;
   assign repeat_md = (mode_r == MD_REPEAT);
   assign running   = en_r & ~arm_r & (cnt_r != '0);
   assign expire    = running & (cnt_r == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_r <= '0;
      end else if (load_we) begin
         load_r <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_r   <= 1'b0;
         mode_r <= MD_ONCE;
         arm_r  <= 1'b0;
      end else begin
         arm_r <= ctrl_we & start;
         if (ctrl_we) begin
            en_r   <= wdata[CTRL_EN_BIT];
            mode_r <= wdata[CTRL_MODE_LSB +: MODE_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_r <= '0;
      end else if (arm_r) begin
         cnt_r <= eff_load;
      end else if (expire && repeat_md) begin
         cnt_r <= eff_load;
      end else if (running) begin
         cnt_r <= cnt_r - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_r <= 1'b0;
      end else if (expire) begin
         pend_r <= 1'b1;
      end else if (ack_re) begin
         pend_r <= 1'b0;
      end
   end

   assign load_val = load_r;
   assign en       = en_r;
   assign mode     = mode_r;
   assign count    = cnt_r;
   assign pending  = pend_r;

   // R4: an armed start loads the reload value
   assert_start_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_r && load_r != '0 && !load_we) |=> (cnt_r == $past(load_r)));

   // R7: zero reload acts as one
   assert_zero_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_r && load_r == '0) |=> (cnt_r == ONE));

   // R5: a finished one-shot rests at zero
   assert_oneshot_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_r && !arm_r && !repeat_md && cnt_r == '0 && !ctrl_we) |=> (cnt_r == '0));

   // R6: a running repeating channel never shows zero
   assert_repeat_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_r && !arm_r && repeat_md && cnt_r != '0 && !ctrl_we) |=> (cnt_r != '0));

   // R8: a stopped channel holds its count
   assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_r && !ctrl_we) |=> $stable(cnt_r));

   // R9: pending holds until acknowledged
   assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_r && !ack_re) |=> pend_r);

   // R11: expiry beats a same-cycle acknowledge
   assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (en_r && !arm_r && cnt_r == ONE && ack_re) |=> pend_r);

endmodule

// File: rtl/dcnt_regdec.sv
module dcnt_regdec
   import dcnt_pkg::*;
#(
   parameter int NUM_CH    = 3,
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter bit REG_RDATA = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             addr,
   input  logic                          wr,
   input  logic                          rd,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  ch_load,
   input  logic [NUM_CH-1:0]             ch_en,
   input  logic [NUM_CH-1:0][MODE_W-1:0] ch_mode,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  ch_count,
   input  logic [NUM_CH-1:0]             ch_pend,
   output logic [NUM_CH-1:0]             load_we,
   output logic [NUM_CH-1:0]             ctrl_we,
   output logic [NUM_CH-1:0]             ack_re,
   output logic [DATA_W-1:0]             rdata
);

   localparam int CH_IDX_W = $clog2(NUM_CH);
   localparam int BASE_W   = REG_IDX_W + CH_IDX_W;
   localparam logic [CH_IDX_W:0] NUM_CH_V = (CH_IDX_W+1)'(NUM_CH);

   logic [CH_IDX_W-1:0] ch_sel;
   reg_idx_e            reg_sel;
   logic                hi_zero;
   logic                ch_ok;
   logic [DATA_W-1:0]   rd_val;

   assign ch_sel  = addr[REG_IDX_W +: CH_IDX_W];
   assign reg_sel = reg_idx_e'(addr[REG_IDX_W-1:0]);

   generate
      if (ADDR_W > BASE_W) begin : g_hi_chk
         assign hi_zero = ~|addr[ADDR_W-1:BASE_W];
      end else begin : g_no_hi
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign ch_ok = hi_zero & ({1'b0, ch_sel} < NUM_CH_V);

   always_comb begin
      load_we = '0;
      ctrl_we = '0;
      ack_re  = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_ok && ch_sel == CH_IDX_W'(i)) begin
            load_we[i] = wr & (reg_sel == RI_LOAD);
            ctrl_we[i] = wr & (reg_sel == RI_CTRL);
            ack_re[i]  = rd & (reg_sel == RI_ACK);
         end
      end
   end

   always_comb begin
      rd_val = '0;
      if (ch_ok) begin
         case (reg_sel)
            RI_LOAD:   rd_val[CNT_W-1:0] = ch_load[ch_sel];
            RI_CTRL: begin
               rd_val[CTRL_EN_BIT]                = ch_en[ch_sel];
               rd_val[CTRL_MODE_LSB +: MODE_W]    = ch_mode[ch_sel];
            end
            RI_COUNT:  rd_val[CNT_W-1:0] = ch_count[ch_sel];
            RI_STATUS: rd_val[0]         = ch_pend[ch_sel];
            default:   rd_val = '0;
         endcase
      end
   end

   generate
      if (REG_RDATA) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata <= '0;
            end else if (rd) begin
               rdata <= rd_val;
            end
         end
      end else begin : g_rd_comb
         assign rdata = rd ? rd_val : '0;
      end
   endgenerate

   // R2: at most one register strobe per access
   assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_we, ctrl_we, ack_re}));

   // R2: unmapped channel numbers raise no strobe
   assert_unmapped_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_ok |-> ({load_we, ctrl_we, ack_re} == '0));

endmodule

// File: rtl/dcnt_timer_bank.sv
module dcnt_timer_bank
   import dcnt_pkg::*;
#(
   parameter int NUM_CH    = 3,
   parameter int CNT_W     = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 5,
   parameter bit REG_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] irq
);

   localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int MIN_AW   = REG_IDX_W + CH_IDX_W;

   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("dcnt_timer_bank: NUM_CH must be at least 2");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("dcnt_timer_bank: CNT_W must lie in 2..DATA_W");
      end
      if (DATA_W < CTRL_MODE_LSB + MODE_W) begin : g_bad_data
         $error("dcnt_timer_bank: DATA_W too narrow for the control word");
      end
      if (ADDR_W < MIN_AW) begin : g_bad_addr
         $error("dcnt_timer_bank: ADDR_W too narrow for the channel count");
      end
   endgenerate

   logic [NUM_CH-1:0]             load_we;
   logic [NUM_CH-1:0]             ctrl_we;
   logic [NUM_CH-1:0]             ack_re;
   logic [NUM_CH-1:0][CNT_W-1:0]  ch_load;
   logic [NUM_CH-1:0][CNT_W-1:0]  ch_count;
   logic [NUM_CH-1:0][MODE_W-1:0] ch_mode;
   logic [NUM_CH-1:0]             ch_en;
   logic [NUM_CH-1:0]             ch_pend;

   dcnt_regdec #(
      .NUM_CH    (NUM_CH),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .REG_RDATA (REG_RDATA)
   ) i_regdec (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .wr       (bus_wr),
      .rd       (bus_rd),
      .ch_load  (ch_load),
      .ch_en    (ch_en),
      .ch_mode  (ch_mode),
      .ch_count (ch_count),
      .ch_pend  (ch_pend),
      .load_we  (load_we),
      .ctrl_we  (ctrl_we),
      .ack_re   (ack_re),
      .rdata    (bus_rdata)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         dcnt_channel #(
            .CNT_W (CNT_W)
         ) i_channel (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_we  (load_we[c]),
            .ctrl_we  (ctrl_we[c]),
            .ack_re   (ack_re[c]),
            .wdata    (bus_wdata[CNT_W-1:0]),
            .load_val (ch_load[c]),
            .en       (ch_en[c]),
            .mode     (ch_mode[c]),
            .count    (ch_count[c]),
            .pending  (ch_pend[c])
         );
      end
   endgenerate

   assign irq = ch_pend;

endmodule

// File: tb/test_dcnt_timer_bank.sv
`timescale 1ns/1ps
module test_dcnt_timer_bank;

   localparam int NUM_CH = 3;
   localparam int ADDR_W = 5;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic              bus_rd = 1'b0;
   logic [DATA_W-1:0] bus_rdata;
   logic [NUM_CH-1:0] irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   dcnt_timer_bank i_dcnt_timer_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   function automatic logic [ADDR_W-1:0] ra(input int ch, input int idx);
      return ADDR_W'(ch * 8 + idx);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // entered at a falling edge; returns at the falling edge after the write clock
   task automatic wr(input int ch, input int idx, input logic [31:0] d);
      bus_addr = ra(ch, idx); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int ch, input int idx, output logic [31:0] d);
      bus_addr = ra(ch, idx); bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 irq", 32'(irq), 0);
      chk("R1 rdata", bus_rdata, 0);
      rd(0, 1, v); chk("R1 ctrl", v, 0);
      rd(0, 2, v); chk("R1 count", v, 0);
      rd(2, 0, v); chk("R1 load", v, 0);
      rd(1, 3, v); chk("R1 status", v, 0);
   endtask

   task automatic t_map();
      logic [31:0] v;
      wr(1, 0, 32'hDEADBEEF);
      rd(1, 0, v); chk("R2 load readback", v, 32'hDEADBEEF);
      wr(2, 2, 32'h1234);
      rd(2, 2, v); chk("R2 count write ignored", v, 0);
      wr(1, 3, 32'h1);
      rd(1, 3, v); chk("R2 status write ignored", v, 0);
      chk("R2 irq untouched", 32'(irq), 0);
      wr(3, 0, 32'hFFFF);
      rd(3, 0, v); chk("R2 unmapped channel", v, 0);
      rd(0, 5, v); chk("R2 unmapped index", v, 0);
      rd(0, 0, v); chk("R2 neighbour load untouched", v, 0);
   endtask

   task automatic t_ctrl();
      logic [31:0] v;
      wr(0, 1, 32'hFFFF_FFFA);
      rd(0, 1, v); chk("R3 ctrl bits only", v, 32'h2);
      wr(0, 1, 32'h0);
      rd(0, 1, v); chk("R3 ctrl cleared", v, 0);
   endtask

   task automatic t_oneshot();
      logic [31:0] v;
      wr(0, 0, 5);
      wr(0, 1, 32'h1);
      idle(1);
      rd(0, 2, v); chk("R4 loaded value", v, 5);
      rd(0, 2, v); chk("R4 first decrement", v, 4);
      idle(2);
      chk("R5 no early expiry", 32'(irq), 0);
      idle(1);
      chk("R5 expiry on time R12 others quiet", 32'(irq), 32'h1);
      rd(0, 2, v); chk("R5 count at zero", v, 0);
      idle(4);
      rd(0, 2, v); chk("R5 count rests", v, 0);
      wr(0, 1, 32'h0);
      rd(0, 3, v); chk("R9 status while disabled", v, 1);
      chk("R9 irq held", 32'(irq), 32'h1);
      rd(0, 4, v); chk("R10 ack data", v, 0);
      chk("R10 irq cleared", 32'(irq), 0);
      rd(0, 3, v); chk("R10 status cleared", v, 0);
   endtask

   task automatic t_periodic();
      logic [31:0] v;
      wr(1, 0, 4);
      wr(1, 1, 32'h3);
      idle(4);
      chk("R6 first period not yet", 32'(irq[1]), 0);
      idle(1);
      chk("R6 first expiry", 32'(irq[1]), 1);
      rd(1, 4, v);
      chk("R10 periodic ack", 32'(irq[1]), 0);
      idle(2);
      chk("R6 quiet mid period", 32'(irq[1]), 0);
      idle(1);
      chk("R6 second expiry after N", 32'(irq[1]), 1);
      idle(3);
      rd(1, 4, v);
      chk("R11 set wins over ack", 32'(irq[1]), 1);
      rd(1, 4, v);
      chk("R11 later ack clears", 32'(irq[1]), 0);
      rd(1, 1, v); chk("R3 repeat mode readback", v, 32'h3);
      wr(1, 1, 32'h2);
      rd(1, 2, v); chk("R6 count never zero", 32'(v != 0), 1);
   endtask

   task automatic t_zero();
      logic [31:0] v;
      wr(2, 0, 0);
      wr(2, 1, 32'h1);
      idle(1);
      chk("R7 not before load", 32'(irq[2]), 0);
      idle(1);
      chk("R7 zero reload expires", 32'(irq[2]), 1);
      rd(2, 4, v);
      wr(2, 1, 32'h0);
      chk("R7 cleared", 32'(irq[2]), 0);
   endtask

   task automatic t_freeze();
      logic [31:0] v;
      wr(0, 0, 100);
      wr(0, 1, 32'h1);
      idle(10);
      wr(0, 1, 32'h0);
      rd(0, 2, v); chk("R8 frozen value", v, 90);
      idle(5);
      rd(0, 2, v); chk("R8 still frozen", v, 90);
      chk("R8 no irq", 32'(irq[0]), 0);
      wr(0, 1, 32'h1);
      idle(1);
      rd(0, 2, v); chk("R8 restart reloads", v, 100);
      wr(0, 1, 32'h0);
   endtask

   task automatic t_indep();
      logic [31:0] v;
      wr(1, 0, 3);
      wr(2, 0, 7);
      wr(1, 1, 32'h1);
      wr(2, 1, 32'h1);
      idle(2);
      chk("R12 none yet", 32'(irq), 0);
      idle(1);
      chk("R12 ch1 alone", 32'(irq), 32'h2);
      idle(4);
      chk("R12 ch2 not yet", 32'(irq), 32'h2);
      idle(1);
      chk("R12 both pending", 32'(irq), 32'h6);
      rd(1, 4, v);
      chk("R12 ack ch1 only", 32'(irq), 32'h4);
      rd(2, 4, v);
      chk("R12 ack ch2", 32'(irq), 0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_map();
      t_ctrl();
      t_oneshot();
      t_periodic();
      t_zero();
      t_freeze();
      t_indep();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule